// File: doc/BRIEF.md
# Serial Receive Queue with Overflow Policy

This block buffers frames that a serial peripheral has finished receiving, until the host or a DMA engine collects them. A completed frame first lands in a one-word holding stage that stands in for the receive shift register. On the next cycle it moves into a four-entry, 16-bit queue, provided the queue has room. The host reads the oldest entry combinationally on `popData` and removes it with a one-cycle `popReq` strobe. A clear strobe empties both the queue and the holding stage.

The block reports how full it is as one count that includes the holding stage. While the queue holds data, it raises a drain request, and a direction bit sends that request to either a DMA line or an interrupt line. An overflow happens when a frame arrives while the queue is full and the holding stage is still occupied. It sets a sticky flag, and a mode bit decides what happens to the new frame: it either replaces the held word or is thrown away. A sticky transmit-underflow flag, set by an event strobe from the slave transmit side, has its own interrupt enable.

While the module-disable input is high, the buffer is frozen. Frames, pops and clears change nothing, and `popData` still shows the oldest entry.

Top module: `spi_rx_queue`

## Requirements
- R1: After reset, `entryCount` is 0, both flags are 0, all four request outputs are 0 and `popData` is 0.
- R2: A completed frame is held for one cycle and then enters the queue. Frames leave the queue in arrival order. `popData` shows the oldest entry whenever the queue is not empty.
- R3: `entryCount` equals the number of queue entries plus 1 when the holding stage is occupied. Its maximum is 5 (depth 4 plus the holding stage).
- R4: A drain request exists when the queue is not empty and `drainEn`=1. With `drainToDma`=1 it appears only on `drainDma`, and with `drainToDma`=0 it appears only on `drainIrq`.
- R5: A frame that arrives while the queue is full and the holding stage is occupied sets `ovfFlag`. The flag stays set until an `ovfClear` pulse clears it.
- R6: `ovfIrq` is high exactly when `ovfFlag`=1 and `ovfIntEn`=1.
- R7: On overflow with `overwriteEn`=1, the new frame replaces the held word. With `overwriteEn`=0 the new frame is discarded and the held word is kept.
- R8: A pop of an empty queue returns 0 and leaves `entryCount` unchanged.
- R9: `clearReq` empties the queue and the holding stage. A frame arriving in the same cycle as a clear is dropped.
- R10: While `moduleOff`=1, frames, pops and clears leave `entryCount` and the contents unchanged, and `popData` still shows the oldest entry.
- R11: A `txUnderflowEvt` pulse sets a sticky `underflowFlag`, and an `underflowClear` pulse clears it. `underflowIrq` is high exactly when the flag and `underflowIntEn` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameDone | input | 1 | Frame-complete strobe |
| frameData | input | 16 | Received frame word |
| popReq | input | 1 | Host pop strobe |
| clearReq | input | 1 | Empty queue and holding stage |
| ovfClear | input | 1 | Write-one-to-clear for the overflow flag |
| txUnderflowEvt | input | 1 | Transmit underflow event |
| underflowClear | input | 1 | Write-one-to-clear for the underflow flag |
| drainEn | input | 1 | Drain request enable |
| drainToDma | input | 1 | 1 = DMA line, 0 = interrupt line |
| ovfIntEn | input | 1 | Overflow interrupt enable |
| underflowIntEn | input | 1 | Underflow interrupt enable |
| overwriteEn | input | 1 | Overflow policy: 1 = keep the new frame |
| moduleOff | input | 1 | Module-disable freeze |
| popData | output | 16 | Oldest entry, 0 when the queue is empty |
| entryCount | output | 3 | Queue entries plus the holding stage |
| ovfFlag | output | 1 | Sticky overflow flag |
| underflowFlag | output | 1 | Sticky transmit underflow flag |
| drainDma | output | 1 | Drain request, DMA line |
| drainIrq | output | 1 | Drain request, interrupt line |
| ovfIrq | output | 1 | Overflow interrupt |
| underflowIrq | output | 1 | Underflow interrupt |

## Verification
The hardest state to reach is the overflow itself: the queue must be full and the holding stage occupied in the same cycle that another frame arrives. Because the holding stage empties into the queue one cycle after each frame, the bench first sends five frames with no pops. That fills the four queue slots and leaves the fifth frame held. The bench then sends a sixth frame, once with each setting of the policy bit. The scoreboard queue is changed to match each policy: the sixth value is dropped in one case and replaces the last expected entry in the other.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef struct packed {
    logic flush;   // empty queue and holding stage
    logic moveSh;  // holding stage -> queue tail
    logic loadSh;  // frameData -> holding stage
    logic popHead; // retire the oldest entry
  } dpStrobe_t;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int EW = $clog2(DEPTH + 2)
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      frameDone,
  input  logic      popReq,
  input  logic      clearReq,
  input  logic      ovfClear,
  input  logic      txUnderflowEvt,
  input  logic      underflowClear,
  input  logic      drainEn,
  input  logic      drainToDma,
  input  logic      ovfIntEn,
  input  logic      underflowIntEn,
  input  logic      overwriteEn,
  input  logic      moduleOff,
  output dpStrobe_t strobes,
  output logic      fifoEmpty,
  output logic [EW-1:0] entryCount,
  output logic      ovfFlag,
  output logic      underflowFlag,
  output logic      drainDma,
  output logic      drainIrq,
  output logic      ovfIrq,
  output logic      underflowIrq
);
  logic [CW-1:0] fifoCnt;
  logic shHold;
  logic active, fifoFull, flush, moveSh, popOk, frameOk, ovfEvt, loadSh;

  assign active   = !moduleOff;
  assign fifoFull = (fifoCnt == CW'(DEPTH));
  assign flush    = active && clearReq;
  assign moveSh   = active && !flush && shHold && !fifoFull;
  assign popOk    = active && !flush && popReq && (fifoCnt != '0);
  assign frameOk  = active && !flush && frameDone;
  assign ovfEvt   = frameOk && shHold && fifoFull;
  assign loadSh   = frameOk && (!shHold || moveSh || overwriteEn);

  assign strobes = '{flush: flush, moveSh: moveSh, loadSh: loadSh, popHead: popOk};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoCnt <= '0;
      shHold  <= 1'b0;
    end else if (flush) begin
      fifoCnt <= '0;
      shHold  <= 1'b0;
    end else begin
      fifoCnt <= fifoCnt + CW'(moveSh) - CW'(popOk);
      if (loadSh)      shHold <= 1'b1;
      else if (moveSh) shHold <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag       <= 1'b0;
      underflowFlag <= 1'b0;
    end else begin
      if (ovfEvt)        ovfFlag <= 1'b1;
      else if (ovfClear) ovfFlag <= 1'b0;
      if (txUnderflowEvt)      underflowFlag <= 1'b1;
      else if (underflowClear) underflowFlag <= 1'b0;
    end
  end

  assign fifoEmpty    = (fifoCnt == '0);
  assign entryCount   = EW'(fifoCnt) + EW'(shHold);
  assign drainDma     = drainEn && !fifoEmpty && drainToDma;
  assign drainIrq     = drainEn && !fifoEmpty && !drainToDma;
  assign ovfIrq       = ovfFlag && ovfIntEn;
  assign underflowIrq = underflowFlag && underflowIntEn;

  // R3
  count_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    entryCount <= EW'(DEPTH + 1));

  // R5
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && !moduleOff && !clearReq && shHold && fifoFull) |=> ovfFlag);

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ovfClear) |=> ovfFlag);

  // R10
  frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    moduleOff |=> $stable(entryCount));

  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && fifoEmpty && !shHold && !frameDone) |=> (entryCount == '0));
endmodule

// File: rtl/rxq_data.sv
module rxq_data
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int WIDTH = 16,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobes,
  input  logic [WIDTH-1:0] frameData,
  input  logic             fifoEmpty,
  output logic [WIDTH-1:0] popData
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] shData;
  logic [PW-1:0] wrPtr, rdPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      shData <= '0;
    end else if (strobes.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobes.moveSh)  wrPtr <= wrPtr + PW'(1);
      if (strobes.popHead) rdPtr <= rdPtr + PW'(1);
      if (strobes.loadSh)  shData <= frameData;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.moveSh && !strobes.flush) mem[wrPtr] <= shData;
  end

  assign popData = fifoEmpty ? '0 : mem[rdPtr];

  // R9
  flush_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flush |=> (wrPtr == rdPtr));

  // R2
  idle_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.moveSh && !strobes.flush) |=> $stable(wrPtr));
endmodule

// File: rtl/spi_rx_queue.sv
module spi_rx_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int WIDTH = 16,
  localparam int EW = $clog2(DEPTH + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameDone,
  input  logic [WIDTH-1:0] frameData,
  input  logic             popReq,
  input  logic             clearReq,
  input  logic             ovfClear,
  input  logic             txUnderflowEvt,
  input  logic             underflowClear,
  input  logic             drainEn,
  input  logic             drainToDma,
  input  logic             ovfIntEn,
  input  logic             underflowIntEn,
  input  logic             overwriteEn,
  input  logic             moduleOff,
  output logic [WIDTH-1:0] popData,
  output logic [EW-1:0]    entryCount,
  output logic             ovfFlag,
  output logic             underflowFlag,
  output logic             drainDma,
  output logic             drainIrq,
  output logic             ovfIrq,
  output logic             underflowIrq
);
  dpStrobe_t strobes;
  logic fifoEmpty;

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk, .rstN, .frameDone, .popReq, .clearReq, .ovfClear,
    .txUnderflowEvt, .underflowClear, .drainEn, .drainToDma,
    .ovfIntEn, .underflowIntEn, .overwriteEn, .moduleOff,
    .strobes, .fifoEmpty, .entryCount, .ovfFlag, .underflowFlag,
    .drainDma, .drainIrq, .ovfIrq, .underflowIrq
  );

  rxq_data #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_data (
    .clk, .rstN, .strobes, .frameData, .fifoEmpty, .popData
  );
endmodule

// File: tb/spi_rx_queue_bench.sv
module spi_rx_queue_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameDone = 0, popReq = 0, clearReq = 0, ovfClear = 0;
  logic txUnderflowEvt = 0, underflowClear = 0, drainEn = 0, drainToDma = 0;
  logic ovfIntEn = 0, underflowIntEn = 0, overwriteEn = 0, moduleOff = 0;
  logic [15:0] frameData = '0;
  logic [15:0] popData;
  logic [2:0] entryCount;
  logic ovfFlag, underflowFlag, drainDma, drainIrq, ovfIrq, underflowIrq;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;
  logic [15:0] expQ[$];

  always #2.5 clk = ~clk;

  spi_rx_queue u_spi_rx_queue (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: sends a frame, records it in the scoreboard if it is expected to survive
  task automatic sendFrame(input logic [15:0] d, input bit keep);
    @(negedge clk);
    frameDone = 1; frameData = d;
    @(negedge clk);
    frameDone = 0;
    if (keep) expQ.push_back(d);
  endtask

  // monitor: pops from the design and compares with the scoreboard head
  task automatic popCheck(input string req);
    logic [15:0] exp;
    exp = (expQ.size() != 0) ? expQ.pop_front() : 16'h0;
    @(negedge clk);
    popReq = 1;
    #1 chk(popData == exp, req, popData, exp);
    @(negedge clk);
    popReq = 0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R1 reset state
    chk(entryCount == 0, "R1 count", entryCount, 0);
    chk({ovfFlag, underflowFlag} == 0, "R1 flags", {ovfFlag, underflowFlag}, 0);
    chk({drainDma, drainIrq, ovfIrq, underflowIrq} == 0, "R1 requests",
        {drainDma, drainIrq, ovfIrq, underflowIrq}, 0);
    chk(popData == 0, "R1 popData", popData, 0);

    // R2 / R3 / R4 ordering, count, drain routing
    sendFrame(16'hA001, 1);
    #1 chk(entryCount == 1, "R3 held frame counted", entryCount, 1);
    sendFrame(16'hA002, 1);
    sendFrame(16'hA003, 1);
    idle(1);
    #1 chk(entryCount == 3, "R3 three entries", entryCount, 3);
    chk({drainDma, drainIrq} == 0, "R4 drain disabled", {drainDma, drainIrq}, 0);
    drainEn = 1; drainToDma = 1;
    #1 chk({drainDma, drainIrq} == 2'b10, "R4 routed to dma", {drainDma, drainIrq}, 2);
    drainToDma = 0;
    #1 chk({drainDma, drainIrq} == 2'b01, "R4 routed to irq", {drainDma, drainIrq}, 1);
    popCheck("R2 order 1");
    popCheck("R2 order 2");
    popCheck("R2 order 3");
    #1 chk({drainDma, drainIrq} == 0, "R4 empty no request", {drainDma, drainIrq}, 0);

    // R8 pop of empty
    popCheck("R8 empty pop data");
    #1 chk(entryCount == 0, "R8 count unchanged", entryCount, 0);

    // R5 / R6 / R7 overflow with discard
    for (int i = 0; i < 5; i++) sendFrame(16'hB000 + 16'(i), 1);
    idle(1);
    #1 chk(entryCount == 5, "R3 saturated count", entryCount, 5);
    chk(ovfFlag == 0, "R5 no overflow yet", ovfFlag, 0);
    sendFrame(16'hBEEF, 0);
    #1 chk(ovfFlag == 1, "R5 overflow flagged", ovfFlag, 1);
    chk(entryCount == 5, "R3 count stays 5", entryCount, 5);
    chk(ovfIrq == 0, "R6 irq masked", ovfIrq, 0);
    ovfIntEn = 1;
    #1 chk(ovfIrq == 1, "R6 irq enabled", ovfIrq, 1);
    for (int i = 0; i < 5; i++) popCheck("R7 discard policy");
    #1 chk(ovfFlag == 1, "R5 flag sticky", ovfFlag, 1);
    pulse(ovfClear);
    #1 chk(ovfFlag == 0, "R5 flag cleared", ovfFlag, 0);
    chk(ovfIrq == 0, "R6 irq follows flag", ovfIrq, 0);

    // R7 overwrite policy
    overwriteEn = 1;
    for (int i = 0; i < 5; i++) sendFrame(16'hC000 + 16'(i), 1);
    idle(1);
    sendFrame(16'hCAFE, 0);
    expQ[$] = 16'hCAFE;
    #1 chk(ovfFlag == 1, "R5 overflow again", ovfFlag, 1);
    for (int i = 0; i < 5; i++) popCheck("R7 overwrite policy");
    overwriteEn = 0;
    pulse(ovfClear);

    // R10 module disable freeze
    sendFrame(16'hD001, 1);
    sendFrame(16'hD002, 1);
    idle(1);
    moduleOff = 1;
    @(negedge clk); popReq = 1;
    #1 chk(popData == expQ[0], "R10 frozen pop data", popData, expQ[0]);
    @(negedge clk); popReq = 0;
    pulse(clearReq);
    sendFrame(16'hDEAD, 0);
    idle(1);
    #1 chk(entryCount == 2, "R10 state frozen", entryCount, 2);
    moduleOff = 0;
    popCheck("R10 after resume 1");
    popCheck("R10 after resume 2");

    // R9 clear
    sendFrame(16'hE001, 1);
    sendFrame(16'hE002, 1);
    sendFrame(16'hE003, 1);
    pulse(clearReq);
    expQ.delete();
    #1 chk(entryCount == 0, "R9 cleared count", entryCount, 0);
    chk(popData == 0, "R9 cleared data", popData, 0);
    @(negedge clk); clearReq = 1; frameDone = 1; frameData = 16'hE0FF;
    @(negedge clk); clearReq = 0; frameDone = 0;
    idle(1);
    #1 chk(entryCount == 0, "R9 clear beats frame", entryCount, 0);

    // R11 transmit underflow
    pulse(txUnderflowEvt);
    #1 chk(underflowFlag == 1, "R11 flag set", underflowFlag, 1);
    chk(underflowIrq == 0, "R11 irq masked", underflowIrq, 0);
    underflowIntEn = 1;
    idle(2);
    #1 chk(underflowIrq == 1, "R11 irq sticky", underflowIrq, 1);
    pulse(underflowClear);
    #1 chk({underflowFlag, underflowIrq} == 0, "R11 cleared",
           {underflowFlag, underflowIrq}, 0);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule